// File: doc/BRIEF.md
# Configuration Access Address Qualifier

This block sits between a host-side request channel and the indirect configuration port of a bus bridge. Each request names a target (a bus/device/function identifier), a register offset, an access size of 1, 2 or 4 bytes and a direction. The block screens the request against the bridge's addressing rules. A legal request produces a one-cycle downstream strobe carrying the indirect address word and, for writes, the byte strobes and the data already shifted onto the matching lanes of a 32-bit data window. A refused request produces no downstream activity and returns an error code instead.

The rules depend on two plain control inputs. `express_mode` selects the larger offset range and refuses non-zero functions on bus 0. `bridge_broken` refuses everything. Responses come back one per request on a valid/ready channel. A response carries a status code (0 = success, 1 = parameter error, 2 = hardware error) and the read data. The downstream window answers reads combinationally on `dn_rdata`, in the same cycle as the strobe.

Back-pressure rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response appears on the following cycle. The block holds one response. `req_ready` is high when no response is pending, or when the pending one is being taken in the same cycle (`rsp_ready` high). A stalled response keeps its status and data unchanged until it is taken.

Top module: `cfg_access_qualifier`

## Requirements
- R1: An identifier with any bit set above bit 15 is refused with status 1 (parameter error).
- R2: An offset above 0xFF with `express_mode` low, or above 0xFFF with `express_mode` high, is refused with status 1. Offsets 0x100 to 0xFFF are legal in express mode.
- R3: An offset that is not a multiple of the access size (offset & (size-1) non-zero) is refused with status 1.
- R4: An access size other than 1, 2 or 4 is refused with status 1.
- R5: With `express_mode` high, a request to bus 0 (identifier bits 15:8 zero) whose identifier bits 7:0 are non-zero is refused with status 2 (hardware error). With `express_mode` low the same request is legal.
- R6: A request whose device field (identifier bits 7:3) equals 31 is refused with status 2.
- R7: While `bridge_broken` is high, every request that passes the parameter checks is refused with status 2.
- R8: When both a parameter rule and a hardware rule fail, the status is 1.
- R9: For a legal request, `dn_addr` is: bit 31 = 1, bits 27:24 = offset bits 11:8, bits 23:8 = identifier, bits 7:0 = offset bits 7:0. All other bits are 0.
- R10: A legal write strobes lanes little-endian (lane k is `dn_wdata[8k+7:8k]`). A byte write uses lane offset&3 and a halfword write uses lanes offset&3 and offset&3+1, each taking the data from the low bits of `req_wdata`. A word write uses all four lanes. A read drives `dn_wstrb` to 0.
- R11: A legal read returns the addressed lanes of `dn_rdata`, right-justified and zero-extended: a byte from lane offset&3, a halfword from lanes offset&3 upward, a word as is.
- R12: A refused read returns 0x000000FF for size 1, 0x0000FFFF for size 2 and 0xFFFFFFFF otherwise. Every write response carries read data 0.
- R13: `dn_valid` is high only in the cycle a legal request is accepted. The response status is 0 exactly for such requests.
- R14: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response status and data are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| express_mode | input | 1 | 1 = express bus rules, 0 = conventional |
| bridge_broken | input | 1 | Bridge in broken state; refuse all requests |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_id | input | 17 | Bus/device/function identifier (bit 16 out of range) |
| req_offset | input | 13 | Register offset |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_status | output | 2 | 0 success, 1 parameter error, 2 hardware error |
| rsp_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Downstream access strobe |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Indirect address word |
| dn_wstrb | output | 4 | Data window byte strobes |
| dn_wdata | output | 32 | Data window write lanes |
| dn_rdata | input | 32 | Data window read lanes |

## Verification
The main function is tried with a vector table. The table mixes legal byte, halfword and word reads and writes at every lane position, so a wrong lane shift or strobe pattern shows up. Pairs of requests differ in one input only: the same bus-0 request in both modes, offset 0x100 in both modes, and device 30 next to device 31. These pairs separate the mode-dependent rules from the unconditional ones. Requests that break a parameter rule and a hardware rule together check the precedence. Refused reads of each size check the all-ones fill. A directed stall sequence holds `rsp_ready` low while a second request waits, which shows that the response is held and the request is not accepted.

// File: rtl/cfg_aq_pkg.sv
package cfg_aq_pkg;

  typedef enum logic [1:0] {
    CST_OK    = 2'd0,
    CST_PARAM = 2'd1,
    CST_HW    = 2'd2
  } cfg_status_e;

  // Fill value returned by a refused read, by access size (R12)
  function automatic logic [31:0] fail_fill(input logic [2:0] size);
    case (size)
      3'd1:    fail_fill = 32'h0000_00FF;
      3'd2:    fail_fill = 32'h0000_FFFF;
      default: fail_fill = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_aq_check.sv
module cfg_aq_check
  import cfg_aq_pkg::*;
#(
  parameter int ID_IN_W   = 17,
  parameter int ID_W      = 16,
  parameter int OFF_W     = 13,
  parameter int CONV_MAX  = 255,
  parameter int EXP_MAX   = 4095,
  parameter int DEV_LSB   = 3,
  parameter int DEV_W     = 5,
  parameter int BUS_LSB   = 8
) (
  input  logic [ID_IN_W-1:0] id,
  input  logic [OFF_W-1:0]   offset,
  input  logic [2:0]         size,
  input  logic               express,
  input  logic               broken,
  output cfg_status_e        status
);

  localparam logic [DEV_W-1:0] DEV_SPECIAL = '1;

  logic id_over, off_over, size_bad, misaligned;
  logic root_func, dev_special;
  logic param_err, hw_err;

  assign id_over    = |id[ID_IN_W-1:ID_W];
  assign off_over   = express ? (offset > OFF_W'(EXP_MAX)) : (offset > OFF_W'(CONV_MAX));
  assign size_bad   = !(size == 3'd1 || size == 3'd2 || size == 3'd4);
  assign misaligned = |(offset[2:0] & (size - 3'd1));

  assign root_func   = express && (id[ID_W-1:BUS_LSB] == '0) && (id[BUS_LSB-1:0] != '0);
  assign dev_special = (id[DEV_LSB+DEV_W-1:DEV_LSB] == DEV_SPECIAL);

  assign param_err = id_over || off_over || size_bad || misaligned;
  assign hw_err    = root_func || dev_special || broken;

  // Parameter checks take precedence over hardware checks
  always_comb begin
    if (param_err)   status = CST_PARAM;
    else if (hw_err) status = CST_HW;
    else             status = CST_OK;
  end

endmodule

// File: rtl/cfg_aq_lanes.sv
module cfg_aq_lanes #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane_sel,
  input  logic [2:0]                  size,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [DATA_W-1:0]           win_rdata,
  output logic [DATA_W/8-1:0]         wstrb,
  output logic [DATA_W-1:0]           wlanes,
  output logic [DATA_W-1:0]           rd_value
);

  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  logic full;
  assign full = (size == 3'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] rel;
    logic             hit;
    assign rel = SEL_W'(i) - lane_sel;
    assign hit = full || (size == 3'd1 && rel == '0) || (size == 3'd2 && rel <= SEL_W'(1));
    assign wstrb[i]        = hit;
    assign wlanes[i*8 +: 8] = hit ? wdata[{rel, 3'b000} +: 8] : 8'h00;
  end

  logic [DATA_W-1:0] shifted;
  assign shifted = win_rdata >> {lane_sel, 3'b000};

  always_comb begin
    case (size)
      3'd1:    rd_value = {{(DATA_W-8){1'b0}},  shifted[7:0]};
      3'd2:    rd_value = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: rd_value = win_rdata;
    endcase
  end

endmodule

// File: rtl/cfg_aq_rsp.sv
module cfg_aq_rsp
  import cfg_aq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  cfg_status_e       load_status,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output cfg_status_e       rsp_status,
  output logic [DATA_W-1:0] rsp_data,
  output logic              can_accept
);

  assign can_accept = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= CST_OK;
      rsp_data   <= '0;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_status <= load_status;
      rsp_data   <= load_data;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_access_qualifier.sv
module cfg_access_qualifier
  import cfg_aq_pkg::*;
#(
  parameter int ID_IN_W  = 17,
  parameter int ID_W     = 16,
  parameter int OFF_W    = 13,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int CONV_MAX = 255,
  parameter int EXP_MAX  = 4095
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  express_mode,
  input  logic                  bridge_broken,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ID_IN_W-1:0]    req_id,
  input  logic [OFF_W-1:0]      req_offset,
  input  logic [2:0]            req_size,
  input  logic                  req_write,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_status,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  dn_valid,
  output logic                  dn_write,
  output logic [ADDR_W-1:0]     dn_addr,
  output logic [DATA_W/8-1:0]   dn_wstrb,
  output logic [DATA_W-1:0]     dn_wdata,
  input  logic [DATA_W-1:0]     dn_rdata
);

  localparam int LANES   = DATA_W / 8;
  localparam int SEL_W   = $clog2(LANES);
  localparam int LOW_W   = 8;
  localparam int EXT_W   = 4;
  localparam int ID_LSB  = LOW_W;
  localparam int EXT_LSB = ID_LSB + ID_W;
  localparam int EN_BIT  = ADDR_W - 1;

  cfg_status_e       chk_status;
  cfg_status_e       rsp_st;
  logic              accept, legal;
  logic [LANES-1:0]  lane_strb;
  logic [DATA_W-1:0] lane_wdata, lane_rd, rsp_load_data;
  logic [ADDR_W-1:0] addr_word;

  cfg_aq_check #(
    .ID_IN_W (ID_IN_W),
    .ID_W    (ID_W),
    .OFF_W   (OFF_W),
    .CONV_MAX(CONV_MAX),
    .EXP_MAX (EXP_MAX)
  ) i_check (
    .id     (req_id),
    .offset (req_offset),
    .size   (req_size),
    .express(express_mode),
    .broken (bridge_broken),
    .status (chk_status)
  );

  cfg_aq_lanes #(.DATA_W(DATA_W)) i_lanes (
    .lane_sel (req_offset[SEL_W-1:0]),
    .size     (req_size),
    .wdata    (req_wdata),
    .win_rdata(dn_rdata),
    .wstrb    (lane_strb),
    .wlanes   (lane_wdata),
    .rd_value (lane_rd)
  );

  assign accept = req_valid && req_ready;
  assign legal  = (chk_status == CST_OK);

  // Indirect address word: enable, extended offset, identifier, low offset
  always_comb begin
    addr_word = '0;
    addr_word[EN_BIT] = 1'b1;
    addr_word[EXT_LSB +: EXT_W] = req_offset[LOW_W +: EXT_W];
    addr_word[ID_LSB +: ID_W]   = req_id[ID_W-1:0];
    addr_word[LOW_W-1:0]        = req_offset[LOW_W-1:0];
  end

  assign dn_valid = accept && legal;
  assign dn_write = req_write;
  assign dn_addr  = addr_word;
  assign dn_wstrb = req_write ? lane_strb : '0;
  assign dn_wdata = req_write ? lane_wdata : '0;

  always_comb begin
    if (req_write)  rsp_load_data = '0;
    else if (legal) rsp_load_data = lane_rd;
    else            rsp_load_data = DATA_W'(fail_fill(req_size));
  end

  cfg_aq_rsp #(.DATA_W(DATA_W)) i_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_status(chk_status),
    .load_data  (rsp_load_data),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_st),
    .rsp_data   (rsp_rdata),
    .can_accept (req_ready)
  );

  assign rsp_status = rsp_st;

endmodule

// File: rtl/cfg_aq_checker.sv
module cfg_aq_checker #(
  parameter int ID_IN_W = 17,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bridge_broken,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ID_IN_W-1:0]  req_id,
  input logic [2:0]          req_size,
  input logic                dn_valid,
  input logic                dn_write,
  input logic [ADDR_W-1:0]   dn_addr,
  input logic [DATA_W/8-1:0] dn_wstrb,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [1:0]          rsp_status,
  input logic [DATA_W-1:0]   rsp_rdata
);

  logic acc;
  assign acc = req_valid && req_ready;

  a_r1_wide_id_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && |req_id[ID_IN_W-1:16]) |-> !dn_valid);

  a_r6_special_dev_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_id[7:3] == 5'h1f) |-> !dn_valid);

  a_r7_broken_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bridge_broken) |-> !dn_valid);

  a_r9_addr_enable_id: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_addr[ADDR_W-1] && dn_addr[23:8] == req_id[15:0]));

  a_r10_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write) |-> ($countones(dn_wstrb) == 32'(req_size)));

  a_r10_read_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_write) |-> (dn_wstrb == '0));

  a_r13_reject_status: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dn_valid) |=> (rsp_valid && rsp_status != 2'd0));

  a_r13_accept_status: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dn_valid) |=> (rsp_valid && rsp_status == 2'd0));

  a_r14_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r14_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)));

endmodule

bind cfg_access_qualifier cfg_aq_checker #(
  .ID_IN_W(ID_IN_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_cfg_aq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bridge_broken(bridge_broken),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_id       (req_id),
  .req_size     (req_size),
  .dn_valid     (dn_valid),
  .dn_write     (dn_write),
  .dn_addr      (dn_addr),
  .dn_wstrb     (dn_wstrb),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_status   (rsp_status),
  .rsp_rdata    (rsp_rdata)
);

// File: tb/test_cfg_access_qualifier.sv
`timescale 1ns/1ps
module test_cfg_access_qualifier;

  localparam logic [31:0] WINDOW = 32'h4433_2211;

  typedef struct packed {
    logic [16:0] id;
    logic [12:0] off;
    logic [2:0]  size;
    logic        wr;
    logic        expr;
    logic        brk;
    logic [31:0] wdata;
    logic [1:0]  st;
    logic [31:0] rdata;
    logic [3:0]  strb;
    logic [31:0] wlane;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R11 legal reads
    '{17'h00108, 13'h010, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h44332211, 4'h0, 32'h0, 4'd11},
    '{17'h00108, 13'h013, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h00000044, 4'h0, 32'h0, 4'd11},
    '{17'h00210, 13'h00E, 3'd2, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0, 32'h00004433, 4'h0, 32'h0, 4'd11},
    // R10 legal writes
    '{17'h00108, 13'h041, 3'd1, 1'b1, 1'b0, 1'b0, 32'h000000AB, 2'd0, 32'h0, 4'b0010, 32'h0000AB00, 4'd10},
    '{17'h00108, 13'h006, 3'd2, 1'b1, 1'b0, 1'b0, 32'h0000BEEF, 2'd0, 32'h0, 4'b1100, 32'hBEEF0000, 4'd10},
    '{17'h00300, 13'h104, 3'd4, 1'b1, 1'b1, 1'b0, 32'h12345678, 2'd0, 32'h0, 4'b1111, 32'h12345678, 4'd10},
    // R1 identifier range
    '{17'h10000, 13'h000, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd1},
    // R2 offset range per mode
    '{17'h00108, 13'h100, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'h000000FF, 4'h0, 32'h0, 4'd2},
    '{17'h00108, 13'h100, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0, 32'h00000011, 4'h0, 32'h0, 4'd2},
    '{17'h00108, 13'h1000, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 2'd1, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd2},
    // R3 alignment
    '{17'h00108, 13'h002, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd3},
    '{17'h00108, 13'h001, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'h0000FFFF, 4'h0, 32'h0, 4'd3},
    // R4 illegal size
    '{17'h00108, 13'h000, 3'd3, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd4},
    // R5 bus 0 rule, mode dependent
    '{17'h00008, 13'h000, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 2'd2, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd5},
    '{17'h00008, 13'h000, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h44332211, 4'h0, 32'h0, 4'd5},
    '{17'h00000, 13'h000, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0, 32'h44332211, 4'h0, 32'h0, 4'd5},
    // R6 device 31 vs 30
    '{17'h001F8, 13'h000, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0, 2'd2, 32'h0000FFFF, 4'h0, 32'h0, 4'd6},
    '{17'h001F0, 13'h000, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h00002211, 4'h0, 32'h0, 4'd6},
    // R7 broken bridge
    '{17'h00108, 13'h000, 3'd1, 1'b0, 1'b0, 1'b1, 32'h0, 2'd2, 32'h000000FF, 4'h0, 32'h0, 4'd7},
    '{17'h00108, 13'h000, 3'd4, 1'b1, 1'b0, 1'b1, 32'hCAFEF00D, 2'd2, 32'h0, 4'h0, 32'h0, 4'd7},
    // R8 precedence
    '{17'h00108, 13'h003, 3'd2, 1'b0, 1'b0, 1'b1, 32'h0, 2'd1, 32'h0000FFFF, 4'h0, 32'h0, 4'd8},
    '{17'h000F8, 13'h1000, 3'd4, 1'b0, 1'b1, 1'b0, 32'h0, 2'd1, 32'hFFFFFFFF, 4'h0, 32'h0, 4'd8},
    // R12 refused write returns zero data
    '{17'h10108, 13'h000, 3'd4, 1'b1, 1'b0, 1'b0, 32'h55555555, 2'd1, 32'h0, 4'h0, 32'h0, 4'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        express_mode = 1'b0, bridge_broken = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, dn_valid, dn_write;
  logic [16:0] req_id = '0;
  logic [12:0] req_offset = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [3:0]  dn_wstrb;
  logic [31:0] dn_rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  assign dn_rdata = WINDOW;  // simple downstream responder

  always #4 clk = ~clk;

  cfg_access_qualifier i_cfg_access_qualifier (
    .clk(clk), .rst_n(rst_n), .express_mode(express_mode), .bridge_broken(bridge_broken),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_offset(req_offset),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wstrb(dn_wstrb),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      4'd13: return "R13"; default: return "R14";
    endcase
  endfunction

  // R9 address word layout computed from the requirement text
  function automatic logic [31:0] exp_addr(input logic [16:0] id, input logic [12:0] off);
    return {1'b1, 3'b000, off[11:8], id[15:0], off[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string r;
    r = rname(v.req);
    @(negedge clk);
    req_id = v.id; req_offset = v.off; req_size = v.size; req_write = v.wr;
    req_wdata = v.wdata; express_mode = v.expr; bridge_broken = v.brk;
    req_valid = 1'b1; rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R14", $sformatf("vec%0d ready", idx), 32'(req_ready), 32'd1);
    check(dn_valid == (v.st == 2'd0), "R13", $sformatf("vec%0d %s strobe", idx, r),
          32'(dn_valid), 32'(v.st == 2'd0));
    if (v.st == 2'd0) begin
      check(dn_addr == exp_addr(v.id, v.off), "R9", $sformatf("vec%0d addr", idx),
            dn_addr, exp_addr(v.id, v.off));
      if (v.wr) begin
        check(dn_wstrb == v.strb, r, $sformatf("vec%0d wstrb", idx), 32'(dn_wstrb), 32'(v.strb));
        check(dn_wdata == v.wlane, r, $sformatf("vec%0d wdata", idx), dn_wdata, v.wlane);
      end else begin
        check(dn_wstrb == 4'h0, "R10", $sformatf("vec%0d read strobe", idx), 32'(dn_wstrb), 32'h0);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, r, $sformatf("vec%0d rsp_valid", idx), 32'(rsp_valid), 32'd1);
    check(rsp_status == v.st, r, $sformatf("vec%0d status", idx), 32'(rsp_status), 32'(v.st));
    check(rsp_rdata == v.rdata, r, $sformatf("vec%0d rdata", idx), rsp_rdata, v.rdata);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    check(rsp_valid == 1'b0, "R14", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(req_ready == 1'b1, "R14", "reset req_ready", 32'(req_ready), 32'd1);
    check(dn_valid == 1'b0, "R13", "reset dn_valid", 32'(dn_valid), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R14 directed stall: first response held while a second request waits
    @(negedge clk);
    express_mode = 1'b0; bridge_broken = 1'b0;
    req_id = 17'h00108; req_offset = 13'h000; req_size = 3'd4; req_write = 1'b0;
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    req_offset = 13'h001; req_size = 3'd1;
    #1;
    check(req_ready == 1'b0, "R14", "stall ready", 32'(req_ready), 32'd0);
    check(dn_valid == 1'b0, "R14", "stall strobe", 32'(dn_valid), 32'd0);
    check(rsp_rdata == 32'h44332211, "R14", "stall data", rsp_rdata, 32'h44332211);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R14", "held valid", 32'(rsp_valid), 32'd1);
    check(rsp_rdata == 32'h44332211, "R14", "held data", rsp_rdata, 32'h44332211);
    check(rsp_status == 2'd0, "R14", "held status", 32'(rsp_status), 32'd0);
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R14", "release ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata == 32'h00000022, "R11", "second byte after stall", rsp_rdata, 32'h00000022);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R14", "drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R14 actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule